// File: doc/BRIEF.md
# Store-and-Forward Ingress Gate with Route Lookup

This block sits at the entry of one switch port. It writes each incoming AXI-Stream packet into a local word buffer. It holds the packet there until the last beat has been stored and the packet's destination is known. The destination is resolved in one of two ways. A packet can name its own output port on its first beat. Otherwise the block takes a 16-bit endpoint identifier from the first word and sends it to a shared route table over a valid/ready request channel, then waits for the answer on a second valid/ready channel.

Once released, every beat of the packet carries the same destination port and a hit flag. When the table reports no match, the destination is replaced by a fixed fallback port set by a parameter, and the flag is low. Resolved destinations wait in a small queue of their own. This lets the next packet be received while an earlier one is still draining.

Top module: `ingress_route_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 and `out_valid`, `lk_req_valid` and `lk_rsp_ready` are 0.
- R2: `out_valid` is 1 exactly when the oldest unsent packet has had its final beat accepted and its destination resolved. It rises in the cycle after the later of those two handshakes.
- R3: The buffer holds 2^MTU words. `in_ready` is 0 while all of them are occupied. A packet of exactly 2^MTU words is stored and forwarded without losing a beat.
- R4: For a packet whose first beat has `in_tid` other than 1, the block raises `lk_req_valid` in the cycle after that beat, with `lk_req_epid` equal to bits [15:0] of the first word. Both stay unchanged until `lk_req_ready`. No further first beat is accepted until the response has been taken.
- R5: A packet whose first beat has `in_tid` equal to 1 issues no lookup request. It leaves with `out_dest` equal to the `in_dest` of its first beat and with `out_keep` at 1.
- R6: A lookup response with `lk_rsp_hit` at 1 gives the packet `out_dest` equal to `lk_rsp_port` and `out_keep` at 1 on every beat.
- R7: A lookup response with `lk_rsp_hit` at 0 gives the packet `out_dest` equal to the DEFAULT_PORT parameter and `out_keep` at 0 on every beat.
- R8: Beats leave in arrival order with unchanged data, and `out_last` is set on each packet's final beat only. Outputs hold steady while `out_ready` is 0. Once a packet starts, its beats follow without gaps, and its destination and hit flag stay constant.
- R9: At most 2^RFIFO_LOG resolved destinations may be waiting. While that many are queued, a new first beat is refused with `in_ready` at 0. Body beats of a packet are still accepted while an earlier packet drains.
- R10: `lk_rsp_ready` is 1 only after a request has been accepted and until its response has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Incoming beat |
| in_dest | input | DEST_W | Supplied destination, read on the first beat |
| in_tid | input | 2 | Routing mode from the first beat: 1 = use in_dest, other = look up |
| in_last | input | 1 | Final beat of the packet |
| in_valid | input | 1 | Incoming beat valid |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| out_data | output | DATA_W | Outgoing beat |
| out_dest | output | DEST_W | Resolved destination port |
| out_keep | output | 1 | 1 = destination supplied or found, 0 = fallback port |
| out_last | output | 1 | Final beat of the outgoing packet |
| out_valid | output | 1 | Outgoing beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| lk_req_epid | output | 16 | Endpoint identifier to look up |
| lk_req_valid | output | 1 | Lookup request pending |
| lk_req_ready | input | 1 | Table accepts the request |
| lk_rsp_port | input | DEST_W | Port returned by the table |
| lk_rsp_hit | input | 1 | Table found a match |
| lk_rsp_valid | input | 1 | Response present |
| lk_rsp_ready | output | 1 | Block takes the response |

## Verification
The bench aims at release timing. A block that let a packet out before its last beat was stored, or before a slow lookup came back, would raise `out_valid` a cycle early. A block that waited an extra stage would be caught as one cycle late. It fills the buffer with a single maximum-length packet while the output is stalled; an off-by-one in the occupancy limit would either drop a beat or deadlock. It also stalls the output behind several single-beat packets with their own destinations, to make the destination queue refuse a new first beat. A missing full check there would overwrite a destination and mislabel later packets. Mixed runs with gaps, back-pressure and lookup misses catch a fallback port applied to the wrong packet, and a request issued for a packet that named its own port.

// File: rtl/irg_pkg.sv
package irg_pkg;
   localparam int EPID_W = 16;
   localparam logic [1:0] TID_DIRECT = 2'd1;

   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_REQ  = 2'd1,
      LK_WAIT = 2'd2
   } lk_state_e;
endpackage

// File: rtl/irg_pkt_store.sv
module irg_pkt_store #(
   parameter int WIDTH = 64,
   parameter int MTU   = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_last,
   output logic             full,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_last,
   output logic             pkt_avail
);
   localparam int DEPTH = 2 ** MTU;
   localparam int CNT_W = MTU + 1;

   logic [WIDTH:0]     mem [DEPTH];
   logic [MTU-1:0]     wr_ptr, rd_ptr;
   logic [CNT_W-1:0]   word_cnt, pkt_cnt;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= {wr_last, wr_data};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         word_cnt <= '0;
         pkt_cnt  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         word_cnt <= word_cnt + CNT_W'(wr_en) - CNT_W'(rd_en);
         pkt_cnt  <= pkt_cnt + CNT_W'(wr_en && wr_last) - CNT_W'(rd_en && rd_last);
      end
   end

   assign {rd_last, rd_data} = mem[rd_ptr];
   assign full      = (word_cnt == CNT_W'(DEPTH));
   assign pkt_avail = (pkt_cnt != '0);

   // R3: a write never lands on a full buffer
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> word_cnt < CNT_W'(DEPTH));
   // R3: complete packets never outnumber stored words
   p_pkt_in_words_r3: assert property (@(posedge clk) disable iff (rst)
      pkt_cnt <= word_cnt);
   // R2: reads only come from a completely stored packet
   p_read_complete_r2: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> pkt_cnt != '0);
endmodule

// File: rtl/irg_route_fifo.sv
module irg_route_fifo #(
   parameter int WIDTH = 4,
   parameter int LOG   = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   output logic             full,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty
);
   localparam int DEPTH = 2 ** LOG;

   generate
      if (LOG == 0) begin : g_single
         logic             held;
         logic [WIDTH-1:0] slot;
         always_ff @(posedge clk) begin
            if (rst) begin
               held <= 1'b0;
               slot <= '0;
            end else begin
               if (push) begin
                  held <= 1'b1;
                  slot <= din;
               end else if (pop) begin
                  held <= 1'b0;
               end
            end
         end
         assign full  = held;
         assign empty = !held;
         assign dout  = slot;
      end else begin : g_ring
         logic [WIDTH-1:0] mem [DEPTH];
         logic [LOG-1:0]   wp, rp;
         logic [LOG:0]     cnt;
         always_ff @(posedge clk) begin
            if (push) mem[wp] <= din;
         end
         always_ff @(posedge clk) begin
            if (rst) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else begin
               if (push) wp <= wp + 1'b1;
               if (pop)  rp <= rp + 1'b1;
               cnt <= cnt + (LOG+1)'(push) - (LOG+1)'(pop);
            end
         end
         assign full  = (cnt == (LOG+1)'(DEPTH));
         assign empty = (cnt == '0);
         assign dout  = mem[rp];
      end
   endgenerate

   // R9: a destination is only queued when there is room
   p_push_room_r9: assert property (@(posedge clk) disable iff (rst)
      push |-> !full);
   // R2: a destination is only consumed when one is queued
   p_pop_data_r2: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);
endmodule

// File: rtl/irg_lookup_ctl.sv
module irg_lookup_ctl
   import irg_pkg::*;
#(
   parameter int DEST_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [EPID_W-1:0] start_epid,
   output logic              idle,
   output logic [EPID_W-1:0] req_epid,
   output logic              req_valid,
   input  logic              req_ready,
   input  logic [DEST_W-1:0] rsp_port,
   input  logic              rsp_hit,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   output logic              done,
   output logic [DEST_W-1:0] done_port,
   output logic              done_hit
);
   lk_state_e state;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= LK_IDLE;
         req_epid <= '0;
      end else begin
         unique case (state)
            LK_IDLE: if (start) begin
               req_epid <= start_epid;
               state    <= LK_REQ;
            end
            LK_REQ:  if (req_ready) state <= LK_WAIT;
            LK_WAIT: if (rsp_valid) state <= LK_IDLE;
            default: state <= LK_IDLE;
         endcase
      end
   end

   assign idle      = (state == LK_IDLE);
   assign req_valid = (state == LK_REQ);
   assign rsp_ready = (state == LK_WAIT);
   assign done      = rsp_valid && rsp_ready;
   assign done_port = rsp_port;
   assign done_hit  = rsp_hit;

   // R4: request and identifier hold until accepted
   p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
      req_valid && !req_ready |=> req_valid && $stable(req_epid));
   // R4: a new lookup only starts when none is in flight
   p_one_at_a_time_r4: assert property (@(posedge clk) disable iff (rst)
      start |-> idle);
   // R10: an accepted request is followed by readiness for the response
   p_rsp_after_req_r10: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_ready |=> rsp_ready);
   // R10: after the response is taken, readiness drops
   p_rsp_once_r10: assert property (@(posedge clk) disable iff (rst)
      done |=> !rsp_ready && idle);
endmodule

// File: rtl/ingress_route_gate.sv
module ingress_route_gate
   import irg_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter int MTU          = 10,
   parameter int DEST_W       = 4,
   parameter int DEFAULT_PORT = 0,
   parameter int RFIFO_LOG    = 2,
   parameter int EPID_LSB     = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DEST_W-1:0] in_dest,
   input  logic [1:0]        in_tid,
   input  logic              in_last,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [DEST_W-1:0] out_dest,
   output logic              out_keep,
   output logic              out_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [EPID_W-1:0] lk_req_epid,
   output logic              lk_req_valid,
   input  logic              lk_req_ready,
   input  logic [DEST_W-1:0] lk_rsp_port,
   input  logic              lk_rsp_hit,
   input  logic              lk_rsp_valid,
   output logic              lk_rsp_ready
);
   localparam int RENT_W = DEST_W + 1;
   localparam logic [DEST_W-1:0] FALLBACK = DEST_W'(DEFAULT_PORT);

   generate
      if (DATA_W < EPID_LSB + EPID_W) begin : g_bad_data_w
         $error("data word too narrow for the endpoint identifier");
      end
      if (MTU < 1 || MTU > 16) begin : g_bad_mtu
         $error("MTU out of range");
      end
      if (DEST_W < 1 || DEFAULT_PORT < 0 || DEFAULT_PORT >= 2 ** DEST_W) begin : g_bad_port
         $error("fallback port does not fit the destination width");
      end
      if (RFIFO_LOG < 0 || RFIFO_LOG > 8) begin : g_bad_rfifo
         $error("destination queue size out of range");
      end
   endgenerate

   logic              at_hdr;
   logic              in_fire, hdr_fire, direct;
   logic              st_full, st_avail, st_last, st_rd;
   logic              rf_push, rf_pop, rf_full, rf_empty;
   logic [RENT_W-1:0] rf_din, rf_dout;
   logic              lk_start, lk_idle, lk_done, lk_hit;
   logic [DEST_W-1:0] lk_port, route;

   assign direct   = (in_tid == TID_DIRECT);
   assign in_ready = !st_full && (!at_hdr || (lk_idle && !rf_full));
   assign in_fire  = in_valid && in_ready;
   assign hdr_fire = in_fire && at_hdr;
   assign lk_start = hdr_fire && !direct;

   always_ff @(posedge clk) begin
      if (rst) at_hdr <= 1'b1;
      else if (in_fire) at_hdr <= in_last;
   end

   irg_pkt_store #(.WIDTH(DATA_W), .MTU(MTU)) u_store (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (in_fire),
      .wr_data  (in_data),
      .wr_last  (in_last),
      .full     (st_full),
      .rd_en    (st_rd),
      .rd_data  (out_data),
      .rd_last  (st_last),
      .pkt_avail(st_avail)
   );

   irg_lookup_ctl #(.DEST_W(DEST_W)) u_lookup (
      .clk       (clk),
      .rst       (rst),
      .start     (lk_start),
      .start_epid(in_data[EPID_LSB +: EPID_W]),
      .idle      (lk_idle),
      .req_epid  (lk_req_epid),
      .req_valid (lk_req_valid),
      .req_ready (lk_req_ready),
      .rsp_port  (lk_rsp_port),
      .rsp_hit   (lk_rsp_hit),
      .rsp_valid (lk_rsp_valid),
      .rsp_ready (lk_rsp_ready),
      .done      (lk_done),
      .done_port (lk_port),
      .done_hit  (lk_hit)
   );

   assign rf_push = (hdr_fire && direct) || lk_done;
   assign rf_din  = lk_done ? {lk_port, lk_hit} : {in_dest, 1'b1};

   irg_route_fifo #(.WIDTH(RENT_W), .LOG(RFIFO_LOG)) u_routes (
      .clk  (clk),
      .rst  (rst),
      .push (rf_push),
      .din  (rf_din),
      .full (rf_full),
      .pop  (rf_pop),
      .dout (rf_dout),
      .empty(rf_empty)
   );

   assign out_valid = st_avail && !rf_empty;
   assign out_last  = st_last;
   assign out_keep  = rf_dout[0];
   assign route     = rf_dout[RENT_W-1:1];
   assign out_dest  = out_keep ? route : FALLBACK;
   assign st_rd     = out_valid && out_ready;
   assign rf_pop    = st_rd && st_last;

   // R8: outputs hold under back-pressure
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)
                                  && $stable(out_dest) && $stable(out_keep));
   // R8: a started packet continues without gaps and with a fixed route
   p_burst_r8: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && !out_last |=> out_valid && $stable(out_dest) && $stable(out_keep));
   // R5: a packet with a supplied destination raises no request
   p_direct_noreq_r5: assert property (@(posedge clk) disable iff (rst)
      hdr_fire && direct |=> !lk_req_valid);
endmodule

// File: tb/ingress_route_gate_test.sv
`timescale 1ns/1ps
module ingress_route_gate_test;
   localparam int DW    = 32;
   localparam int MTU   = 4;
   localparam int DEPTH = 16;
   localparam int DSTW  = 3;
   localparam int DEF   = 6;
   localparam int RFD   = 4;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [DW-1:0]   in_data = '0;
   logic [DSTW-1:0] in_dest = '0;
   logic [1:0]      in_tid = '0;
   logic            in_last = 1'b0, in_valid = 1'b0, in_ready;
   logic [DW-1:0]   out_data;
   logic [DSTW-1:0] out_dest;
   logic            out_keep, out_last, out_valid, out_ready = 1'b0;
   logic [15:0]     lk_req_epid;
   logic            lk_req_valid, lk_req_ready = 1'b0;
   logic [DSTW-1:0] lk_rsp_port = '0;
   logic            lk_rsp_hit = 1'b0, lk_rsp_valid = 1'b0, lk_rsp_ready;

   always #10 clk = ~clk;

   ingress_route_gate #(.DATA_W(DW), .MTU(MTU), .DEST_W(DSTW), .DEFAULT_PORT(DEF),
                        .RFIFO_LOG(2), .EPID_LSB(0)) uut (
      .clk(clk), .rst(rst), .in_data(in_data), .in_dest(in_dest), .in_tid(in_tid),
      .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_dest(out_dest), .out_keep(out_keep), .out_last(out_last),
      .out_valid(out_valid), .out_ready(out_ready),
      .lk_req_epid(lk_req_epid), .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready),
      .lk_rsp_port(lk_rsp_port), .lk_rsp_hit(lk_rsp_hit), .lk_rsp_valid(lk_rsp_valid),
      .lk_rsp_ready(lk_rsp_ready));

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // stimulus queue entry: {dest, tid, last, data}
   logic [DW+5:0] in_q[$];
   logic [DW:0]   exp_q[$];
   bit            pk_complete[256], pk_resolved[256];
   logic [DSTW-1:0] pk_dest[256];
   logic          pk_keep[256];
   int            pk_kind[256];
   logic [15:0]   pk_epid[256];
   int  n_hdr = 0, head_idx = 0, word_cnt = 0, dent = 0, lk_pkt = 0, delay_cnt = 0;
   bit  at_hdr = 1, outstanding = 0, req_done = 0, resp_pending = 0, in_v = 0, run = 0;
   int  gap_pct = 0, rdy_pct = 100, rreq_pct = 100, rsp_delay = 0;
   int  seq = 0;

   function automatic logic [DSTW-1:0] tbl_port(input logic [15:0] e);
      return e[2:0] ^ e[5:3];
   endfunction
   function automatic logic tbl_hit(input logic [15:0] e);
      return ~e[8];
   endfunction

   task automatic send_pkt(input int nb, input logic [1:0] tid,
                           input logic [DSTW-1:0] dst, input logic [15:0] epid);
      for (int b = 0; b < nb; b++) begin
         logic [DW-1:0] d;
         d = (b == 0) ? {8'hA5, 8'(seq), epid} : {8'(seq), 8'(b), 16'($urandom)};
         in_q.push_back({dst, tid, (b == nb - 1), d});
      end
      seq++;
   endtask

   task automatic drain();
      for (int c = 0; c < 5000; c++) begin
         @(negedge clk);
         if (in_q.size() == 0 && !in_v && exp_q.size() == 0 && n_hdr == head_idx) break;
      end
      repeat (3) @(negedge clk);
   endtask

   // cycle engine: drive at the falling edge, compare with the model, then advance it
   initial begin
      forever begin
         @(negedge clk);
         if (run) begin
            bit exp_ov, exp_ir, exp_rv, exp_rr, fire_in, fire_out, fire_req, fire_rsp;
            logic [DW+5:0] hd;
            if (!in_v && in_q.size() > 0 && ($urandom % 100) >= gap_pct) in_v = 1;
            hd = (in_q.size() > 0) ? in_q[0] : '0;
            in_valid = in_v;
            {in_dest, in_tid, in_last, in_data} = in_v ? hd : '0;
            out_ready    = ($urandom % 100) < rdy_pct;
            lk_req_ready = ($urandom % 100) < rreq_pct;
            lk_rsp_valid = resp_pending && delay_cnt == 0;
            lk_rsp_port  = tbl_port(pk_epid[lk_pkt]);
            lk_rsp_hit   = tbl_hit(pk_epid[lk_pkt]);
            #1;
            exp_ov = (head_idx < n_hdr) && pk_complete[head_idx] && pk_resolved[head_idx];
            chk(out_valid == exp_ov, "R2", "out_valid", out_valid, exp_ov);
            if (exp_ov && out_valid && exp_q.size() > 0) begin
               string tg;
               tg = (pk_kind[head_idx] == 0) ? "R5" : (pk_kind[head_idx] == 1) ? "R6" : "R7";
               chk({out_last, out_data} == exp_q[0], "R8", "last+data",
                   {out_last, out_data}, exp_q[0]);
               chk(out_dest == pk_dest[head_idx], tg, "out_dest", out_dest, pk_dest[head_idx]);
               chk(out_keep == pk_keep[head_idx], tg, "out_keep", out_keep, pk_keep[head_idx]);
            end
            exp_ir = (word_cnt < DEPTH) && (!at_hdr || (!outstanding && dent < RFD));
            chk(in_ready == exp_ir,
                (word_cnt >= DEPTH) ? "R3" : (at_hdr && outstanding) ? "R4" : "R9",
                "in_ready", in_ready, exp_ir);
            exp_rv = outstanding && !req_done;
            chk(lk_req_valid == exp_rv, "R4", "lk_req_valid", lk_req_valid, exp_rv);
            if (exp_rv && lk_req_valid)
               chk(lk_req_epid == pk_epid[lk_pkt], "R4", "lk_req_epid", lk_req_epid, pk_epid[lk_pkt]);
            exp_rr = outstanding && req_done;
            chk(lk_rsp_ready == exp_rr, "R10", "lk_rsp_ready", lk_rsp_ready, exp_rr);

            fire_in  = in_v && in_ready;
            fire_out = exp_ov && out_valid && out_ready;
            fire_req = lk_req_valid && lk_req_ready && exp_rv;
            fire_rsp = lk_rsp_valid && lk_rsp_ready && exp_rr;
            if (resp_pending && delay_cnt > 0) delay_cnt--;
            if (fire_req) begin
               req_done = 1; resp_pending = 1; delay_cnt = rsp_delay;
            end
            if (fire_rsp) begin
               pk_resolved[lk_pkt] = 1; dent++;
               outstanding = 0; resp_pending = 0;
            end
            if (fire_in) begin
               logic [DW+5:0] bt;
               bt = in_q.pop_front();
               in_v = 0;
               exp_q.push_back(bt[DW:0]);
               if (at_hdr) begin
                  int p;
                  p = n_hdr; n_hdr++;
                  pk_epid[p] = bt[15:0];
                  pk_complete[p] = 0;
                  if (bt[DW+2:DW+1] == 2'd1) begin
                     pk_resolved[p] = 1; pk_dest[p] = bt[DW+5:DW+3];
                     pk_keep[p] = 1; pk_kind[p] = 0; dent++;
                  end else begin
                     pk_resolved[p] = 0; outstanding = 1; req_done = 0; lk_pkt = p;
                     if (tbl_hit(bt[15:0])) begin
                        pk_dest[p] = tbl_port(bt[15:0]); pk_keep[p] = 1; pk_kind[p] = 1;
                     end else begin
                        pk_dest[p] = DSTW'(DEF); pk_keep[p] = 0; pk_kind[p] = 2;
                     end
                  end
               end
               word_cnt++;
               if (bt[DW]) pk_complete[n_hdr-1] = 1;
               at_hdr = bt[DW];
            end
            if (fire_out) begin
               logic [DW:0] ob;
               ob = exp_q.pop_front();
               word_cnt--;
               if (ob[DW]) begin head_idx++; dent--; end
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected drained");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      #2;
      chk(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
      chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
      @(negedge clk);
      rst = 0;
      #2;
      chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
      chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
      chk(lk_req_valid == 0, "R1", "lk_req_valid after reset", lk_req_valid, 0);
      chk(lk_rsp_ready == 0, "R1", "lk_rsp_ready after reset", lk_rsp_ready, 0);
      run = 1;

      // basic hit, miss, direct and single-beat packets (R5 R6 R7 R8)
      send_pkt(3, 2'd0, 3'd0, 16'h0012);
      send_pkt(2, 2'd2, 3'd0, 16'h0105);
      send_pkt(4, 2'd1, 3'd3, 16'h0007);
      send_pkt(1, 2'd0, 3'd0, 16'h002c);
      send_pkt(1, 2'd1, 3'd5, 16'h0100);
      send_pkt(1, 2'd3, 3'd0, 16'h01ff);
      drain();

      // full buffer with a maximum-length packet (R3)
      rdy_pct = 0;
      send_pkt(DEPTH, 2'd0, 3'd0, 16'h0031);
      send_pkt(5, 2'd1, 3'd2, 16'h0000);
      repeat (40) @(negedge clk);
      #3;
      chk(in_ready == 0, "R3", "in_ready with full buffer", in_ready, 0);
      chk(out_valid == 1, "R3", "out_valid with full buffer", out_valid, 1);
      rdy_pct = 100;
      drain();

      // destination queue full (R9)
      rdy_pct = 0;
      for (int k = 0; k < 6; k++) send_pkt(1, 2'd1, 3'(k), 16'(k));
      repeat (30) @(negedge clk);
      #3;
      chk(in_ready == 0, "R9", "in_ready with queue full", in_ready, 0);
      chk(out_valid == 1, "R9", "out_valid with queue full", out_valid, 1);
      rdy_pct = 100;
      drain();

      // slow table while body beats keep arriving (R2 R4 R10)
      rsp_delay = 12; rreq_pct = 30;
      send_pkt(8, 2'd0, 3'd0, 16'h0a1b);
      send_pkt(3, 2'd0, 3'd0, 16'h0b00);
      send_pkt(2, 2'd1, 3'd7, 16'h0000);
      drain();

      // mixed traffic with gaps and back-pressure
      gap_pct = 30; rdy_pct = 60; rreq_pct = 50; rsp_delay = 3;
      for (int k = 0; k < 40; k++) begin
         int nb;
         logic [1:0] t;
         nb = 1 + ($urandom % DEPTH);
         t  = (($urandom % 4) == 0) ? 2'd1 : 2'($urandom % 2) * 2'd2;
         send_pkt(nb, t, 3'($urandom), 16'($urandom));
      end
      drain();

      finish_run();
   end
endmodule